// File: doc/BRIEF.md
# Dual-Clock Receive Byte Buffer with Overflow Lockout

This block holds received bytes between a receive MAC path and a system bus. Bytes arrive one per write clock, each with an end-of-packet mark. The system side reads them out four at a time as 32-bit words, on its own clock. The read side sees two flags. The ready flag comes from a programmable fill level or from the presence of a complete packet. The active-low almost-empty flag is only meaningful while a read is being requested.

A write attempt while all 128 bytes are occupied is an overflow. When one happens, the buffer discards its contents and refuses all writes. It also raises a sticky status bit and an interrupt request on the read side. A clear strobe from the read side resolves the error through a handshake across the two clock domains. Both pointers return to zero, and writing resumes into an empty buffer.

Top module: `rxq_cdc_fifo`

## Requirements
- R1: The buffer holds up to 128 bytes. Each read returns the four oldest bytes in write order, with the first-written byte in bits 7:0 and the last in bits 31:24.
- R2: A read is accepted on a read clock edge with rd_en_i high only when at least 4 bytes are held and no error is pending. rd_vld_o is then high for the following cycle, with the word on rd_data_o. Otherwise rd_vld_o stays low.
- R3: A threshold code N on thr_i sets a level of N*8 bytes, and code 0 sets a level of 8 bytes. ready_o is high when the held byte count is at or above the level.
- R4: ready_o falls as soon as a read brings the count below the level, provided no complete packet is held.
- R5: ready_o is high, at any level, while at least one byte marked end-of-packet is held. A packet stops counting once the word holding its marked byte is read.
- R6: ae_no_o is low when rd_en_i is high and fewer than 12 bytes are held. It is high whenever rd_en_i is low.
- R7: A write exactly filling 128 bytes is no overflow. A write attempt while 128 bytes are held drops that byte and discards all buffered data. It drives ovf_o and irq_o high within a few read clocks, and from then on reads return nothing.
- R8: While the error is pending, every write is ignored, including its end-of-packet mark.
- R9: A clr_i pulse while the error is pending drops ovf_o and irq_o on the next read clock. After the handshake completes, the buffer is empty and accepts writes again.
- R10: A clr_i pulse with no error pending has no effect on stored data or any flag.
- R11: After reset, ready_o, rd_vld_o, ovf_o and irq_o are low, and ae_no_o is high with rd_en_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock (receive side) |
| rclk_i | input | 1 | Read clock (system side) |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_en_i | input | 1 | Byte write request |
| wr_data_i | input | 8 | Byte to store |
| wr_eop_i | input | 1 | Marks the byte as last of a packet |
| rd_en_i | input | 1 | Word read request |
| rd_data_o | output | 32 | Word read, first byte in bits 7:0 |
| rd_vld_o | output | 1 | rd_data_o holds a word read on the previous edge |
| thr_i | input | 4 | Ready threshold code, level = code*8 bytes (0 means 8) |
| clr_i | input | 1 | Error clear strobe, read clock |
| ready_o | output | 1 | Fill level reached or a complete packet held |
| ae_no_o | output | 1 | Active-low almost-empty flag during reads |
| ovf_o | output | 1 | Sticky overflow status |
| irq_o | output | 1 | Interrupt request raised by overflow |

## Verification
The bench sweeps threshold codes against fill levels at and just under each level, including code 0. A wrong level mapping there would raise ready on too few bytes, or never raise it. It steps a held rd_en_i through the 12-byte boundary and past empty. A design that counted words wrongly would move the almost-empty edge, and one without an underflow guard would return a valid word from nothing. The overflow sequence fills exactly 128 bytes before the overflowing write and then writes a marked packet while locked. A design that flushed late, kept locked writes, or lost data at exact capacity would show stale data, a false ready, or a premature error. The clear is also pulsed with no error pending; a design that acted on it would drop stored bytes.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;

  typedef struct packed {
    logic              eop;
    logic [BYTE_W-1:0] data;
  } rxq_ent_t;
endpackage

// File: rtl/rxq_sync.sv
`timescale 1ns/1ps
module rxq_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rxq_gray_rx.sv
`timescale 1ns/1ps
// Synchronizes a Gray-coded count and returns it in binary.
module rxq_gray_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_s;

  rxq_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gray_i),
    .q_o   (gray_s)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^gray_s[W-1:i];
  end
endmodule

// File: rtl/rxq_mem.sv
`timescale 1ns/1ps
module rxq_mem import rxq_pkg::*; #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                           wclk_i,
  input  logic                           we_i,
  input  logic [AW-1:0]                  waddr_i,
  input  rxq_ent_t                       wdata_i,
  input  logic [AW-1:0]                  raddr_i,
  output rxq_ent_t [WORD_BYTES-1:0]      rdata_o
);
  rxq_ent_t mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_tap
    logic [AW-1:0] ra;
    assign ra         = raddr_i + AW'(k);
    assign rdata_o[k] = mem_q[ra];
  end
endmodule

// File: rtl/rxq_wr_ctl.sv
`timescale 1ns/1ps
module rxq_wr_ctl import rxq_pkg::*; #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned PW    = AW + 1,
  parameter int unsigned WB_W  = $clog2(WORD_BYTES),
  parameter int unsigned RW    = PW - WB_W
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_eop_i,
  input  logic [RW-1:0]     rword_i,
  input  logic              clr_req_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output rxq_ent_t          wdata_o,
  output logic [PW-1:0]     wptr_g_o,
  output logic [PW-1:0]     wpkt_g_o,
  output logic              err_o
);
  logic [PW-1:0] wptr_q, wptr_d, wpkt_q, wpkt_d, wcnt;
  logic [PW-1:0] wptr_g_q, wpkt_g_q;
  logic          err_q, err_d, lock, full, push;

  assign lock = err_q | clr_req_i;
  assign wcnt = wptr_q - {rword_i, {WB_W{1'b0}}};
  assign full = (wcnt == PW'(DEPTH));
  assign push = wr_en_i & ~lock & ~full;

  always_comb begin
    wptr_d = wptr_q;
    wpkt_d = wpkt_q;
    err_d  = err_q;
    if (clr_req_i) begin
      wptr_d = '0;
      wpkt_d = '0;
      err_d  = 1'b0;
    end else if (wr_en_i && !err_q && full) begin
      err_d = 1'b1;
    end else if (push) begin
      wptr_d = wptr_q + 1'b1;
      if (wr_eop_i) wpkt_d = wpkt_q + 1'b1;
    end
  end

  // Gray registers load from next state so they move with the binary counts.
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      wpkt_q   <= '0;
      wptr_g_q <= '0;
      wpkt_g_q <= '0;
      err_q    <= 1'b0;
    end else begin
      wptr_q   <= wptr_d;
      wpkt_q   <= wpkt_d;
      wptr_g_q <= wptr_d ^ (wptr_d >> 1);
      wpkt_g_q <= wpkt_d ^ (wpkt_d >> 1);
      err_q    <= err_d;
    end
  end

  assign we_o     = push;
  assign waddr_o  = wptr_q[AW-1:0];
  assign wdata_o  = '{eop: wr_eop_i, data: wr_data_i};
  assign wptr_g_o = wptr_g_q;
  assign wpkt_g_o = wpkt_g_q;
  assign err_o    = err_q;

  a_r7_wr_cnt_bound: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !lock |-> (wcnt <= PW'(DEPTH)));

  a_r8_locked_wptr_stable: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (err_q && !clr_req_i) |=> $stable(wptr_q));
endmodule

// File: rtl/rxq_rd_ctl.sv
`timescale 1ns/1ps
module rxq_rd_ctl import rxq_pkg::*; #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned THR_W  = 4,
  parameter int unsigned SETTLE = 3,
  parameter int unsigned AW     = $clog2(DEPTH),
  parameter int unsigned PW     = AW + 1,
  parameter int unsigned WB_W   = $clog2(WORD_BYTES),
  parameter int unsigned RW     = PW - WB_W
) (
  input  logic                         rclk_i,
  input  logic                         rst_ni,
  input  logic                         rd_en_i,
  input  logic [THR_W-1:0]             thr_i,
  input  logic                         clr_i,
  input  logic [PW-1:0]                wptr_i,
  input  logic [PW-1:0]                wpkt_i,
  input  logic                         err_i,
  input  rxq_ent_t [WORD_BYTES-1:0]    rdata_i,
  output logic [AW-1:0]                raddr_o,
  output logic [RW-1:0]                rword_g_o,
  output logic                         clr_req_o,
  output logic [WORD_BYTES*BYTE_W-1:0] rd_data_o,
  output logic                         rd_vld_o,
  output logic                         ready_o,
  output logic                         ae_no_o,
  output logic                         ovf_o,
  output logic                         irq_o
);
  localparam int unsigned THR_STEP = DEPTH >> THR_W;
  localparam int unsigned AE_BYTES = 3 * WORD_BYTES;
  localparam int unsigned SC_W     = $clog2(SETTLE + 1);
  localparam int unsigned EC_W     = WB_W + 1;

  logic [PW-1:0]   rptr_q, rptr_d, rpkt_q, rpkt_d;
  logic [PW-1:0]   cnt, cnt_eff, held, thr_bytes;
  logic [RW-1:0]   rword_d, rword_g_q;
  logic [EC_W-1:0] eops;
  logic [SC_W-1:0] settle_q;
  logic [WORD_BYTES*BYTE_W-1:0] rd_data_q;
  logic            clr_req_q, ovf_q, err_d1_q, rd_vld_q, lock, pop, clr_ok;

  // Locked from error sight until pointers re-settle after the clear.
  assign lock      = err_i | clr_req_q | (settle_q != '0);
  assign cnt       = wptr_i - rptr_q;
  assign cnt_eff   = lock ? '0 : cnt;
  assign held      = lock ? '0 : (wpkt_i - rpkt_q);
  assign pop       = rd_en_i & (cnt_eff >= PW'(WORD_BYTES));
  assign clr_ok    = clr_i & err_i & ~clr_req_q;
  assign thr_bytes = (thr_i == '0) ? PW'(THR_STEP) : PW'(thr_i) * PW'(THR_STEP);

  always_comb begin
    eops = '0;
    for (int k = 0; k < WORD_BYTES; k++) eops = eops + EC_W'(rdata_i[k].eop);
  end

  always_comb begin
    rptr_d = rptr_q;
    rpkt_d = rpkt_q;
    if (err_i) begin
      rptr_d = '0;
      rpkt_d = '0;
    end else if (pop) begin
      rptr_d = rptr_q + PW'(WORD_BYTES);
      rpkt_d = rpkt_q + PW'(eops);
    end
  end

  assign rword_d = rptr_d[PW-1:WB_W];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q    <= '0;
      rpkt_q    <= '0;
      rword_g_q <= '0;
    end else begin
      rptr_q    <= rptr_d;
      rpkt_q    <= rpkt_d;
      rword_g_q <= rword_d ^ (rword_d >> 1);
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_req_q <= 1'b0;
      settle_q  <= '0;
      ovf_q     <= 1'b0;
      err_d1_q  <= 1'b0;
    end else begin
      err_d1_q <= err_i;
      if (!err_i)      clr_req_q <= 1'b0;
      else if (clr_ok) clr_req_q <= 1'b1;
      if (clr_req_q && !err_i)  settle_q <= SC_W'(SETTLE);
      else if (settle_q != '0)  settle_q <= settle_q - 1'b1;
      if (clr_ok)                    ovf_q <= 1'b0;
      else if (err_i && !err_d1_q)   ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_vld_q <= pop;
      if (pop) begin
        for (int k = 0; k < WORD_BYTES; k++) rd_data_q[k*BYTE_W +: BYTE_W] <= rdata_i[k].data;
      end
    end
  end

  assign raddr_o   = rptr_q[AW-1:0];
  assign rword_g_o = rword_g_q;
  assign clr_req_o = clr_req_q;
  assign rd_data_o = rd_data_q;
  assign rd_vld_o  = rd_vld_q;
  assign ready_o   = (cnt_eff >= thr_bytes) | (held != '0);
  assign ae_no_o   = ~(rd_en_i & (cnt_eff < PW'(AE_BYTES)));
  assign ovf_o     = ovf_q;
  assign irq_o     = ovf_q;

  a_r1_rd_cnt_bound: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !lock |-> (cnt <= PW'(DEPTH)));

  a_r5_pkt_bound: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !lock |-> ((wpkt_i - rpkt_q) <= cnt));

  a_r2_no_read_locked: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    lock |=> !rd_vld_o);

  a_r7_flush_on_err: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    err_i |=> (rptr_q == '0) && (rpkt_q == '0));

  a_r9_clr_drops_status: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (clr_i && err_i && !clr_req_q) |=> (!ovf_o && !irq_o && clr_req_o));
endmodule

// File: rtl/rxq_cdc_fifo.sv
`timescale 1ns/1ps
module rxq_cdc_fifo import rxq_pkg::*; #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned THR_W  = 4,
  parameter int unsigned SETTLE = 3
) (
  input  logic                         wclk_i,
  input  logic                         rclk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  input  logic                         wr_eop_i,
  input  logic                         rd_en_i,
  output logic [WORD_BYTES*BYTE_W-1:0] rd_data_o,
  output logic                         rd_vld_o,
  input  logic [THR_W-1:0]             thr_i,
  input  logic                         clr_i,
  output logic                         ready_o,
  output logic                         ae_no_o,
  output logic                         ovf_o,
  output logic                         irq_o
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned PW   = AW + 1;
  localparam int unsigned WB_W = $clog2(WORD_BYTES);
  localparam int unsigned RW   = PW - WB_W;

  logic                      we, err_w, err_r, clr_req_r, clr_req_w;
  logic [AW-1:0]             waddr, raddr;
  rxq_ent_t                  wdata;
  rxq_ent_t [WORD_BYTES-1:0] rdata;
  logic [PW-1:0]             wptr_g, wpkt_g, wptr_r, wpkt_r;
  logic [RW-1:0]             rword_g, rword_w;

  rxq_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  rxq_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .WB_W(WB_W), .RW(RW)) u_wr (
    .wclk_i   (wclk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .wr_eop_i (wr_eop_i),
    .rword_i  (rword_w),
    .clr_req_i(clr_req_w),
    .we_o     (we),
    .waddr_o  (waddr),
    .wdata_o  (wdata),
    .wptr_g_o (wptr_g),
    .wpkt_g_o (wpkt_g),
    .err_o    (err_w)
  );

  rxq_gray_rx #(.W(PW)) u_wptr_x (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wptr_g), .bin_o(wptr_r)
  );

  rxq_gray_rx #(.W(PW)) u_wpkt_x (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wpkt_g), .bin_o(wpkt_r)
  );

  rxq_gray_rx #(.W(RW)) u_rword_x (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rword_g), .bin_o(rword_w)
  );

  rxq_sync #(.W(1)) u_err_x (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(err_w), .q_o(err_r)
  );

  rxq_sync #(.W(1)) u_clr_x (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(clr_req_r), .q_o(clr_req_w)
  );

  rxq_rd_ctl #(
    .DEPTH(DEPTH), .THR_W(THR_W), .SETTLE(SETTLE),
    .AW(AW), .PW(PW), .WB_W(WB_W), .RW(RW)
  ) u_rd (
    .rclk_i   (rclk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .thr_i    (thr_i),
    .clr_i    (clr_i),
    .wptr_i   (wptr_r),
    .wpkt_i   (wpkt_r),
    .err_i    (err_r),
    .rdata_i  (rdata),
    .raddr_o  (raddr),
    .rword_g_o(rword_g),
    .clr_req_o(clr_req_r),
    .rd_data_o(rd_data_o),
    .rd_vld_o (rd_vld_o),
    .ready_o  (ready_o),
    .ae_no_o  (ae_no_o),
    .ovf_o    (ovf_o),
    .irq_o    (irq_o)
  );
endmodule

// File: tb/rxq_cdc_fifo_bench.sv
`timescale 1ns/1ps
module rxq_cdc_fifo_bench;
  logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_eop = 1'b0, rd_en = 1'b0, clr = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  thr = '0;
  logic [31:0] rd_data;
  logic        rd_vld, ready, ae_n, ovf, irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #4 wclk = ~wclk;  // 125 MHz write clock
  always #5 rclk = ~rclk;

  rxq_cdc_fifo u_rxq_cdc_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_eop_i(wr_eop),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_vld_o(rd_vld),
    .thr_i(thr), .clr_i(clr),
    .ready_o(ready), .ae_no_o(ae_n), .ovf_o(ovf), .irq_o(irq)
  );

  typedef struct packed {
    logic [3:0] thr;
    logic [7:0] n;
    logic       eop;
    logic       exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{4'd0,  8'd4,   1'b0, 1'b0},
    '{4'd0,  8'd8,   1'b0, 1'b1},
    '{4'd2,  8'd12,  1'b0, 1'b0},
    '{4'd2,  8'd16,  1'b0, 1'b1},
    '{4'd15, 8'd116, 1'b0, 1'b0},
    '{4'd15, 8'd120, 1'b0, 1'b1},
    '{4'd15, 8'd4,   1'b1, 1'b1},
    '{4'd4,  8'd32,  1'b0, 1'b1},
    '{4'd5,  8'd36,  1'b0, 1'b0},
    '{4'd1,  8'd8,   1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rwait(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic e);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = d; wr_eop = e;
    @(negedge wclk);
    wr_en = 1'b0; wr_eop = 1'b0;
  endtask

  task automatic wr_burst(input int n, input logic [7:0] base, input logic eop_last);
    for (int i = 0; i < n; i++) wr_byte(base + 8'(i), eop_last && (i == n - 1));
  endtask

  task automatic rd_word(output logic vld, output logic [31:0] d);
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    vld = rd_vld;
    d   = rd_data;
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] base, input int j);
    logic [7:0] b;
    b = base + 8'(4 * j);
    return {b + 8'd3, b + 8'd2, b + 8'd1, b};
  endfunction

  task automatic drain(input int nw, input logic [7:0] base);
    logic        v;
    logic [31:0] d;
    for (int j = 0; j < nw; j++) begin
      rd_word(v, d);
      check("R2 read valid", 32'(v), 32'd1);
      check("R1 word order", d, exp_word(base, j));
    end
  endtask

  initial begin : watchdog
    #1600000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic        v;
    logic [31:0] d;

    rwait(3);
    rst_n = 1'b1;
    rwait(3);
    // R11 reset state
    check("R11 ready", 32'(ready), 32'd0);
    check("R11 rd_vld", 32'(rd_vld), 32'd0);
    check("R11 ovf", 32'(ovf), 32'd0);
    check("R11 irq", 32'(irq), 32'd0);
    check("R11 ae_n", 32'(ae_n), 32'd1);

    // R3/R5 threshold and packet vectors
    for (int vi = 0; vi < NVEC; vi++) begin
      thr = VEC[vi].thr;
      wr_burst(int'(VEC[vi].n), 8'(vi * 16), VEC[vi].eop);
      rwait(6);
      if (VEC[vi].eop) check("R5 ready on packet", 32'(ready), 32'(VEC[vi].exp));
      else             check("R3 ready vs level", 32'(ready), 32'(VEC[vi].exp));
      drain(int'(VEC[vi].n) / 4, 8'(vi * 16));
      check("R4 ready after drain", 32'(ready), 32'd0);
    end

    // R4 ready falls once below level
    thr = 4'd2;
    wr_burst(20, 8'h40, 1'b0);
    rwait(6);
    check("R4 ready at 20", 32'(ready), 32'd1);
    rd_word(v, d);
    check("R4 ready at 16", 32'(ready), 32'd1);
    rd_word(v, d);
    check("R4 ready at 12", 32'(ready), 32'd0);
    drain(3, 8'h48);

    // R5 packet held until its last word leaves
    thr = 4'd15;
    wr_burst(8, 8'h70, 1'b1);
    rwait(6);
    check("R5 packet ready", 32'(ready), 32'd1);
    rd_word(v, d);
    check("R5 packet half read", 32'(ready), 32'd1);
    rd_word(v, d);
    check("R5 packet gone", 32'(ready), 32'd0);

    // R6 almost-empty across the 12-byte edge, R2 underflow
    wr_burst(16, 8'hA0, 1'b0);
    rwait(6);
    for (int s = 0; s < 6; s++) begin
      @(negedge rclk);
      rd_en = 1'b1;
      #1;
      check("R6 ae_n during read", 32'(ae_n), (s < 2) ? 32'd1 : 32'd0);
      if (s == 5) check("R2 no read when empty", 32'(rd_vld), 32'd0);
    end
    @(negedge rclk);
    rd_en = 1'b0;
    #1;
    check("R6 ae_n idle", 32'(ae_n), 32'd1);

    // R10 clear with no error
    thr = 4'd0;
    wr_burst(8, 8'h10, 1'b0);
    rwait(6);
    @(negedge rclk); clr = 1'b1;
    @(negedge rclk); clr = 1'b0;
    rwait(8);
    check("R10 ovf stays low", 32'(ovf), 32'd0);
    check("R10 ready kept", 32'(ready), 32'd1);
    drain(2, 8'h10);

    // R1/R7 exact capacity, no overflow
    thr = 4'd15;
    wr_burst(128, 8'h00, 1'b0);
    rwait(8);
    check("R7 full no ovf", 32'(ovf), 32'd0);
    check("R3 ready when full", 32'(ready), 32'd1);
    drain(32, 8'h00);

    // R7 overflow
    wr_burst(128, 8'h80, 1'b0);
    wr_byte(8'hEE, 1'b0);
    rwait(10);
    check("R7 ovf set", 32'(ovf), 32'd1);
    check("R7 irq set", 32'(irq), 32'd1);
    check("R7 flushed ready", 32'(ready), 32'd0);
    rd_word(v, d);
    check("R7 no read after flush", 32'(v), 32'd0);

    // R8 locked writes dropped
    wr_burst(8, 8'h55, 1'b1);
    rwait(4);
    check("R8 locked ovf holds", 32'(ovf), 32'd1);

    // R9 clear
    @(negedge rclk); clr = 1'b1;
    @(negedge rclk); clr = 1'b0;
    check("R9 ovf cleared", 32'(ovf), 32'd0);
    check("R9 irq cleared", 32'(irq), 32'd0);
    rwait(20);
    thr = 4'd0;
    #1;
    check("R8 no packet kept", 32'(ready), 32'd0);
    rd_word(v, d);
    check("R9 empty after clear", 32'(v), 32'd0);
    wr_burst(8, 8'h33, 1'b0);
    rwait(6);
    check("R9 writes resume", 32'(ready), 32'd1);
    drain(2, 8'h33);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule